// File: doc/BRIEF.md
# Character Display Power-On Initialization Sequencer

This block brings a character display controller into a known state each time reset is released. A two-stage synchronizer turns the asynchronous reset input into a clean internal reset. The block then writes the blank character code to every location of the display memory, lowest address first. Next it writes a fixed default value to each of the four mode registers. Two busy flags stay high from reset until this work is done and a minimum busy window has passed, so a host that polls either flag issues no command during initialization.

The busy window is set in clock cycles, computed from the clock frequency and a duration in microseconds. The default is 10 ms at 50 MHz. The memory write port and the register write port feed the display memory and the mode register file, which sit outside this block. Asserting reset at any moment stops the sequence and runs it again from the start.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rstN` is low, and for the first two clock edges after it rises, `busy1` and `busy2` are high and neither `memWe` nor `regWe` is asserted.
- R2: `busy1` and `busy2` always carry the same value, and both are high whenever a memory or register write is issued.
- R3: Counting edge 1 as the third rising clock edge after `rstN` rises, `memWe` is high after edges 1 to MEM_DEPTH and low at all other times. After edge k, `memAddr` equals k-1 and `memData` equals 0x20.
- R4: The busy flags fall after edge max(MEM_DEPTH+6, BUSY_CYCLES+1), where BUSY_CYCLES = CLK_HZ/1e6 * BUSY_US. The window therefore covers both the write sequence and the timed count.
- R5: `regWe` is high after edges MEM_DEPTH+1 to MEM_DEPTH+4. `regSel` steps through 0, 1, 2, 3 in that order.
- R6: Register 0 (line and font) receives 0x01: bit 0 set selects two-line mode, and bit 1 clear selects the 5x8 font.
- R7: Register 1 (entry) receives 0x01: bit 0 set makes the address counter increment, and bit 1 clear means the display does not shift.
- R8: Register 2 (display) receives 0x00: display enable (bit 0), cursor (bit 1), blink (bit 2) and underline (bit 3) are all off.
- R9: Register 3 (character source) receives 0x01: bit 0 set selects the character-generator ROM, and bit 1 clear disables descender shifting for the five descender letters.
- R10: Once the busy flags are low, they stay low and no further write of either kind occurs until reset is asserted again.
- R11: Asserting `rstN` low at any point, including mid-clear and during the timed wait, raises the busy flags and stops writes at once. After release the whole sequence repeats with the R3 timing, starting again at address 0.
- R12: `memWe` and `regWe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset, synchronized internally |
| busy1 | output | 1 | First busy flag, high during initialization |
| busy2 | output | 1 | Second busy flag, high during initialization |
| memWe | output | 1 | Display memory write strobe |
| memAddr | output | $clog2(MEM_DEPTH) | Display memory write address |
| memData | output | 8 | Display memory write data (blank code) |
| regWe | output | 1 | Mode register write strobe |
| regSel | output | 2 | Mode register index |
| regData | output | 8 | Default value for the selected mode register |

## Verification
The bench runs two instances. In one, the timed window is longer than the write sequence. In the other it is shorter, so each of the two terms in R4 decides when the busy flags fall. A design that released busy when the clear finished, or when the count expired, would drop its flags early in one of the two instances. The bench reasserts reset mid-clear and during the timed wait. A design that resumed from its old address or count, rather than restarting, would write the wrong addresses or end the busy window early. Every cycle is compared against a behavioural model, so an off-by-one in the synchronizer depth, in the first clear address or in the register order shows up as a shifted write.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam int DATA_W    = 8;
  localparam int REG_CNT   = 4;
  localparam int REG_SEL_W = 2;

  // Mode register indices; the write order follows these values.
  localparam logic [REG_SEL_W-1:0] SEL_LINEFONT = 2'd0;
  localparam logic [REG_SEL_W-1:0] SEL_ENTRY    = 2'd1;
  localparam logic [REG_SEL_W-1:0] SEL_DISPLAY  = 2'd2;
  localparam logic [REG_SEL_W-1:0] SEL_CHARSRC  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_REGS  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } seqState_e;

  // Strobes from the control into the datapath.
  typedef struct packed {
    logic memWr;
    logic regWr;
  } seqStrobe_t;

  // Power-on defaults per register.
  // linefont : bit0 twoLine=1, bit1 tallFont=0
  // entry    : bit0 addrInc=1, bit1 shiftOn=0
  // display  : bit0 dispOn=0, bit1 cursor=0, bit2 blink=0, bit3 underline=0
  // charsrc  : bit0 romSource=1, bit1 descenderShift=0
  function automatic logic [DATA_W-1:0] regDefault(input logic [REG_SEL_W-1:0] sel);
    logic [DATA_W-1:0] val;
    val = '0;
    case (sel)
      SEL_LINEFONT: val[0] = 1'b1;
      SEL_ENTRY:    val[0] = 1'b1;
      SEL_DISPLAY:  val    = '0;
      SEL_CHARSRC:  val[0] = 1'b1;
      default:      val    = '0;
    endcase
    return val;
  endfunction

endpackage

// File: rtl/lcd_init_rstsync.sv
module lcd_init_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstAsyncN,
  output logic rstSyncN
);

  logic [STAGES-1:0] syncQ;

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) syncQ <= '0;
    else            syncQ <= {syncQ[STAGES-2:0], 1'b1};
  end

  assign rstSyncN = syncQ[STAGES-1];

endmodule

// File: rtl/lcd_init_ctrl.sv
module lcd_init_ctrl
  import lcd_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstSyncN,
  input  logic       addrLast,
  input  logic       regLast,
  input  logic       timeUp,
  output seqStrobe_t strobe,
  output logic       busy
);

  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN) state <= ST_IDLE;
    else           state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE:  nextState = ST_CLEAR;
      ST_CLEAR: begin
        strobe.memWr = 1'b1;
        if (addrLast) nextState = ST_REGS;
      end
      ST_REGS: begin
        strobe.regWr = 1'b1;
        if (regLast) nextState = ST_WAIT;
      end
      ST_WAIT:  if (timeUp) nextState = ST_DONE;
      ST_DONE:  nextState = ST_DONE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_DONE);

endmodule

// File: rtl/lcd_init_dpath.sv
module lcd_init_dpath
  import lcd_init_pkg::*;
#(
  parameter int               MEM_DEPTH   = 80,
  parameter int               BUSY_CYCLES = 500000,
  parameter logic [DATA_W-1:0] BLANK      = 8'h20,
  parameter int               ADDR_W      = $clog2(MEM_DEPTH),
  parameter int               TIME_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rstSyncN,
  input  seqStrobe_t           strobe,
  output logic                 addrLast,
  output logic                 regLast,
  output logic                 timeUp,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memData,
  output logic [REG_SEL_W-1:0] regSel,
  output logic [DATA_W-1:0]    regData
);

  localparam logic [ADDR_W-1:0]    ADDR_END = ADDR_W'(MEM_DEPTH - 1);
  localparam logic [REG_SEL_W-1:0] REG_END  = REG_SEL_W'(REG_CNT - 1);
  localparam logic [TIME_W-1:0]    TIME_END = TIME_W'(BUSY_CYCLES);

  logic [ADDR_W-1:0]    addrCnt;
  logic [REG_SEL_W-1:0] regIdx;
  logic [TIME_W-1:0]    timeCnt;

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN)         addrCnt <= '0;
    else if (strobe.memWr) addrCnt <= addrCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN)         regIdx <= '0;
    else if (strobe.regWr) regIdx <= regIdx + 1'b1;
  end

  // Saturating busy-window counter, running from the first synchronized cycle.
  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN)              timeCnt <= '0;
    else if (timeCnt != TIME_END) timeCnt <= timeCnt + 1'b1;
  end

  assign addrLast = (addrCnt == ADDR_END);
  assign regLast  = (regIdx == REG_END);
  assign timeUp   = (timeCnt == TIME_END);
  assign memAddr  = addrCnt;
  assign memData  = BLANK;
  assign regSel   = regIdx;
  assign regData  = regDefault(regIdx);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BUSY_US   = 10_000,
  parameter int MEM_DEPTH = 80,
  parameter int SYNC_LEN  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  output logic                         busy1,
  output logic                         busy2,
  output logic                         memWe,
  output logic [$clog2(MEM_DEPTH)-1:0] memAddr,
  output logic [7:0]                   memData,
  output logic                         regWe,
  output logic [1:0]                   regSel,
  output logic [7:0]                   regData
);

  localparam int BUSY_CYCLES = (CLK_HZ / 1_000_000) * BUSY_US;
  localparam int ADDR_W      = $clog2(MEM_DEPTH);

  logic       rstSyncN;
  logic       addrLast;
  logic       regLast;
  logic       timeUp;
  logic       busy;
  seqStrobe_t strobe;

  lcd_init_rstsync #(.STAGES(SYNC_LEN)) u_sync (
    .clk       (clk),
    .rstAsyncN (rstN),
    .rstSyncN  (rstSyncN)
  );

  lcd_init_ctrl u_ctrl (
    .clk      (clk),
    .rstSyncN (rstSyncN),
    .addrLast (addrLast),
    .regLast  (regLast),
    .timeUp   (timeUp),
    .strobe   (strobe),
    .busy     (busy)
  );

  lcd_init_dpath #(
    .MEM_DEPTH   (MEM_DEPTH),
    .BUSY_CYCLES (BUSY_CYCLES),
    .BLANK       (8'h20),
    .ADDR_W      (ADDR_W)
  ) u_dpath (
    .clk      (clk),
    .rstSyncN (rstSyncN),
    .strobe   (strobe),
    .addrLast (addrLast),
    .regLast  (regLast),
    .timeUp   (timeUp),
    .memAddr  (memAddr),
    .memData  (memData),
    .regSel   (regSel),
    .regData  (regData)
  );

  assign busy1 = busy;
  assign busy2 = busy;
  assign memWe = strobe.memWr;
  assign regWe = strobe.regWr;

endmodule

// File: rtl/lcd_init_chk.sv
module lcd_init_chk #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BUSY_US   = 10_000,
  parameter int MEM_DEPTH = 80
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         busy1,
  input logic                         busy2,
  input logic                         memWe,
  input logic [$clog2(MEM_DEPTH)-1:0] memAddr,
  input logic                         regWe,
  input logic [1:0]                   regSel
);

  localparam int BUSY_CYCLES = (CLK_HZ / 1_000_000) * BUSY_US;
  localparam int CYC_W       = $clog2(BUSY_CYCLES + 2) + 1;

  logic [CYC_W-1:0] cycSinceRel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycSinceRel <= '0;
    else if (cycSinceRel != {CYC_W{1'b1}}) cycSinceRel <= cycSinceRel + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (busy1 && busy2 && !memWe && !regWe));

  assert_busy_covers_writes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || regWe) |-> (busy1 && busy2));

  assert_clear_starts_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> (memAddr == '0));

  assert_clear_ascends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == $past(memAddr) + 1'b1));

  assert_busy_min_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy1) |-> (cycSinceRel >= CYC_W'(BUSY_CYCLES)));

  assert_reg_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && $past(regWe)) |-> (regSel == $past(regSel) + 1'b1));

  assert_busy_stays_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy1 |=> !busy1);

  assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy1 |-> (!memWe && !regWe));

  assert_write_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, regWe}));

endmodule

bind lcd_init_seq lcd_init_chk #(
  .CLK_HZ    (CLK_HZ),
  .BUSY_US   (BUSY_US),
  .MEM_DEPTH (MEM_DEPTH)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy1   (busy1),
  .busy2   (busy2),
  .memWe   (memWe),
  .memAddr (memAddr),
  .regWe   (regWe),
  .regSel  (regSel)
);

// File: tb/test_lcd_init_seq.sv
module test_lcd_init_seq;

  localparam int DEPTH   = 80;
  localparam int NREG    = 4;
  localparam int B_LONG  = 150;
  localparam int B_SHORT = 20;
  localparam int AW      = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int   checks = 0;
  int   failures = 0;
  int   edgeCnt = 0;
  bit   restartPhase = 1'b0;

  always #2 clk = ~clk;

  logic          bL1, bL2, mwL, rwL;
  logic [AW-1:0] maL;
  logic [7:0]    mdL, rdL;
  logic [1:0]    rsL;
  logic          bS1, bS2, mwS, rwS;
  logic [AW-1:0] maS;
  logic [7:0]    mdS, rdS;
  logic [1:0]    rsS;

  lcd_init_seq #(.CLK_HZ(1_000_000), .BUSY_US(B_LONG), .MEM_DEPTH(DEPTH)) i_lcd_init_seq (
    .clk(clk), .rstN(rstN), .busy1(bL1), .busy2(bL2), .memWe(mwL), .memAddr(maL),
    .memData(mdL), .regWe(rwL), .regSel(rsL), .regData(rdL));

  lcd_init_seq #(.CLK_HZ(1_000_000), .BUSY_US(B_SHORT), .MEM_DEPTH(DEPTH)) i_lcd_init_seqShort (
    .clk(clk), .rstN(rstN), .busy1(bS1), .busy2(bS2), .memWe(mwS), .memAddr(maS),
    .memData(mdS), .regWe(rwS), .regSel(rsS), .regData(rdS));

  // Rising edges seen with reset released.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  task automatic checkVal(string tag, string who, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", tag, who, act, exp, edgeCnt);
    end
  endtask

  function automatic int expDefault(int sel);
    case (sel)
      0: return 8'h01;   // R6
      1: return 8'h01;   // R7
      2: return 8'h00;   // R8
      default: return 8'h01; // R9
    endcase
  endfunction

  task automatic verifyDut(string who, int busyLen, logic b1, logic b2, logic mw,
                           logic [AW-1:0] ma, logic [7:0] md, logic rw,
                           logic [1:0] rs, logic [7:0] rd);
    int e;
    int doneE;
    bit expBusy, expMw, expRw;
    string pre;
    e       = edgeCnt - 2;
    doneE   = (DEPTH + NREG + 2 > busyLen + 1) ? DEPTH + NREG + 2 : busyLen + 1;
    expBusy = (e < doneE);
    expMw   = (e >= 1) && (e <= DEPTH);
    expRw   = (e >= DEPTH + 1) && (e <= DEPTH + NREG);
    pre     = restartPhase ? "R11/" : "";
    if (e <= 0)                             checkVal({pre, "R1"}, who, int'(b1), int'(expBusy));
    else if (e == doneE || e == doneE - 1)  checkVal({pre, "R4"}, who, int'(b1), int'(expBusy));
    else if (e > doneE)                     checkVal({pre, "R10"}, who, int'(b1), int'(expBusy));
    else                                    checkVal({pre, "R2"}, who, int'(b1), int'(expBusy));
    checkVal("R2", who, int'(b2), int'(b1));
    checkVal((e <= 0) ? "R1" : (e > DEPTH + NREG) ? "R10" : {pre, "R3"}, who, int'(mw), int'(expMw));
    checkVal((e <= 0) ? "R1" : (e > DEPTH + NREG) ? "R10" : {pre, "R5"}, who, int'(rw), int'(expRw));
    checkVal("R12", who, int'(mw && rw), 0);
    if (expMw) begin
      checkVal({pre, "R3"}, who, int'(ma), e - 1);
      checkVal("R3", who, int'(md), 8'h20);
    end
    if (expRw) begin
      checkVal({pre, "R5"}, who, int'(rs), e - DEPTH - 1);
      case (e - DEPTH - 1)
        0: checkVal("R6", who, int'(rd), expDefault(0));
        1: checkVal("R7", who, int'(rd), expDefault(1));
        2: checkVal("R8", who, int'(rd), expDefault(2));
        default: checkVal("R9", who, int'(rd), expDefault(3));
      endcase
    end
  endtask

  always @(negedge clk) begin
    verifyDut("long",  B_LONG,  bL1, bL2, mwL, maL, mdL, rwL, rsL, rdL);
    verifyDut("short", B_SHORT, bS1, bS2, mwS, maS, mdS, rwS, rsS, rdS);
  end

  task automatic drive(logic val, int cycles);
    @(posedge clk);
    #1 rstN = val;
    repeat (cycles) @(posedge clk);
  endtask

  initial begin
    drive(1'b0, 5);           // R1 reset state
    drive(1'b1, 200);         // full sequence, both window orderings (R4)
    restartPhase = 1'b1;
    drive(1'b0, 3);           // R11 reassert after completion
    drive(1'b1, 40);          // mid-clear
    drive(1'b0, 3);           // R11 reassert mid-clear
    drive(1'b1, 110);         // long instance in timed wait
    drive(1'b0, 2);           // R11 reassert during wait
    drive(1'b1, 200);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule